// File: doc/BRIEF.md
# Interrupt Vector DMA Channel Dispatcher

This block decides, at the moment the CPU reads an interrupt vector during acknowledge, whether that interrupt goes to one of four micro-DMA channels instead of the normal vector path. Each channel has a write-only start-vector register on a small byte-wide register write bus. A 5-bit field of the acknowledged vector is compared with all four registers at once. The result is a DMA hit flag, a channel index and the vector that is actually delivered. All three are registered and qualified by a one-cycle valid strobe.

The block also models an acknowledge race. If the pending request flag is cleared in the same cycle that the vector is read, the CPU gets a fixed default vector (0x00A0, handled at 0x80A0) and no DMA dispatch happens. A register still at its reset value of zero never matches, so the reset state turns DMA dispatch off.

Top module: `ivec_dma_dispatch`

## Requirements
- R1: After reset all four channel registers hold zero, and ack_valid, dma_hit, dma_chan and vec_out are all zero.
- R2: A write with wr_en high to byte address 0x7C+n (n = 0..3) stores wr_data[7:3] into channel n's register. Writes to any other address change no register.
- R3: ack_valid is high in the cycle after each cycle in which ack_req is high, and low in the cycle after a cycle in which ack_req is low.
- R4: When a channel register is nonzero and equals ack_vector[8:4], the result has dma_hit=1 and dma_chan set to that channel number. vec_out then carries ack_vector unchanged.
- R5: When several channels match, dma_chan is the lowest matching channel number.
- R6: A channel register that holds zero never produces a match, including against a vector whose bits 8:4 are zero.
- R7: When flag_clr is high together with ack_req, the result has vec_out=0x00A0, dma_hit=0 and dma_chan=0, whatever the register contents.
- R8: When there is no match and no race, vec_out equals ack_vector, dma_hit=0 and dma_chan=0. Vector bits outside 8:4 never affect matching.
- R9: A register write in the same cycle as ack_req does not affect that acknowledge's result. It affects the next acknowledge.
- R10: While ack_valid is low, dma_hit, dma_chan and vec_out are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte address |
| wr_data | input | 8 | Register write data, bits 7:3 hold the start-vector field |
| ack_req | input | 1 | Vector read during interrupt acknowledge, one cycle per acknowledge |
| ack_vector | input | 16 | Interrupt vector being read |
| flag_clr | input | 1 | Request flag cleared during this vector read |
| ack_valid | output | 1 | Result strobe, one cycle after ack_req |
| dma_hit | output | 1 | Interrupt is serviced by a DMA channel |
| dma_chan | output | 2 | Winning channel index |
| vec_out | output | 16 | Vector delivered to the CPU |

## Verification
The assertions assume that reset starts low and that flag_clr only has meaning when ack_req is high. They also assume that ack_vector and flag_clr are stable for the cycle in which ack_req is sampled. The bench changes inputs only on falling edges and raises ack_req for single cycles. It drives flag_clr only together with ack_req. It checks each result one edge later, and checks again one edge after that to confirm the result is gone.

// File: rtl/ivec_dma_dispatch.sv
module ivec_dma_dispatch #(
  parameter int              NCH     = 4,
  parameter int              AW      = 8,
  parameter int              DW      = 8,
  parameter int              VW      = 16,
  parameter int              FW      = 5,
  parameter int              FLSB    = 4,
  parameter logic [AW-1:0]   BASE    = 8'h7C,
  parameter logic [VW-1:0]   DEF_VEC = 16'h00A0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [DW-1:0]          wr_data,
  input  logic                   ack_req,
  input  logic [VW-1:0]          ack_vector,
  input  logic                   flag_clr,
  output logic                   ack_valid,
  output logic                   dma_hit,
  output logic [$clog2(NCH)-1:0] dma_chan,
  output logic [VW-1:0]          vec_out
);
  localparam int CW = $clog2(NCH);

  logic [FW-1:0]  sv [NCH];
  logic [NCH-1:0] match;
  logic [FW-1:0]  field;
  logic [CW-1:0]  pick;
  logic           any_hit;
  logic           take_dma;

  assign field = ack_vector[FLSB+FW-1:FLSB];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [AW-1:0] ADDR = BASE + AW'(i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        sv[i] <= '0;
      else if (wr_en && wr_addr == ADDR) sv[i] <= wr_data[DW-1 -: FW];
    end
    assign match[i] = (sv[i] != '0) && (sv[i] == field);
  end

  always_comb begin
    pick = '0;
    for (int i = NCH-1; i >= 0; i--)
      if (match[i]) pick = CW'(i);
  end

  assign any_hit  = |match;
  assign take_dma = ack_req && !flag_clr && any_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_valid <= 1'b0;
      dma_hit   <= 1'b0;
      dma_chan  <= '0;
      vec_out   <= '0;
    end else begin
      ack_valid <= ack_req;
      dma_hit   <= take_dma;
      dma_chan  <= take_dma ? pick : '0;
      vec_out   <= !ack_req ? '0 : (flag_clr ? DEF_VEC : ack_vector);
    end
  end

  p_valid_follows_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> ack_valid);
  p_valid_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_req |=> !ack_valid);
  p_quiet_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_valid |-> (!dma_hit && dma_chan == '0 && vec_out == '0));
  p_race_default_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && flag_clr) |=> (vec_out == DEF_VEC && !dma_hit));
  p_passthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !flag_clr) |=> (vec_out == $past(ack_vector)));
  p_chan_zero_no_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_hit |-> dma_chan == '0);
endmodule

// File: tb/ivec_dma_dispatch_tb.sv
module ivec_dma_dispatch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        ack_req = 1'b0;
  logic [15:0] ack_vector = '0;
  logic        flag_clr = 1'b0;
  logic        ack_valid, dma_hit;
  logic [1:0]  dma_chan;
  logic [15:0] vec_out;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ivec_dma_dispatch u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ack_req(ack_req), .ack_vector(ack_vector), .flag_clr(flag_clr),
    .ack_valid(ack_valid), .dma_hit(dma_hit), .dma_chan(dma_chan), .vec_out(vec_out));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_ack(string req, logic [15:0] v, logic clr, logic exp_hit,
                        logic [1:0] exp_ch, logic [15:0] exp_vec,
                        logic w = 1'b0, logic [7:0] wa = '0, logic [7:0] wd = '0);
    @(negedge clk);
    ack_req = 1'b1; ack_vector = v; flag_clr = clr;
    wr_en = w; wr_addr = wa; wr_data = wd;
    @(posedge clk); #1;
    chk({req, " valid"}, 32'(ack_valid), 32'd1);
    chk({req, " hit"},   32'(dma_hit),   32'(exp_hit));
    chk({req, " chan"},  32'(dma_chan),  32'(exp_ch));
    chk({req, " vec"},   32'(vec_out),   32'(exp_vec));
    @(negedge clk);
    ack_req = 1'b0; flag_clr = 1'b0; wr_en = 1'b0;
    @(posedge clk); #1;
    chk("R3 valid drops", 32'(ack_valid), 32'd0);
    chk("R10 idle outputs", {dma_hit, dma_chan, vec_out}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 reset valid", 32'(ack_valid), 32'd0);
    chk("R1 reset outs", {dma_hit, dma_chan, vec_out}, 32'd0);
    do_ack("R6 zero regs vs zero field", 16'h0000, 1'b0, 1'b0, 2'd0, 16'h0000);
    do_ack("R1 no dispatch after reset", 16'h00A0, 1'b0, 1'b0, 2'd0, 16'h00A0);
  endtask

  task automatic t_match();
    do_write(8'h7C, 8'h50);
    do_ack("R4 ch0 match", 16'h00A0, 1'b0, 1'b1, 2'd0, 16'h00A0);
    do_write(8'h7E, 8'h18);
    do_ack("R4 ch2 match", 16'h0030, 1'b0, 1'b1, 2'd2, 16'h0030);
    do_ack("R8 low bits ignored", 16'hFE3C, 1'b0, 1'b1, 2'd2, 16'hFE3C);
  endtask

  task automatic t_priority();
    do_write(8'h7F, 8'h88);
    do_ack("R5 ch3 alone", 16'h0110, 1'b0, 1'b1, 2'd3, 16'h0110);
    do_write(8'h7D, 8'h88);
    do_ack("R5 ch1 beats ch3", 16'h0110, 1'b0, 1'b1, 2'd1, 16'h0110);
  endtask

  task automatic t_decode();
    do_write(8'h7B, 8'hF8);
    do_write(8'h80, 8'hF8);
    do_ack("R2 stray address ignored", 16'h01F0, 1'b0, 1'b0, 2'd0, 16'h01F0);
    do_ack("R8 passthrough", 16'hBEEF, 1'b0, 1'b0, 2'd0, 16'hBEEF);
  endtask

  task automatic t_race();
    do_ack("R7 race on match", 16'h0030, 1'b1, 1'b0, 2'd0, 16'h00A0);
    do_ack("R7 race on nonmatch", 16'h1234, 1'b1, 1'b0, 2'd0, 16'h00A0);
  endtask

  task automatic t_same_cycle();
    do_ack("R9 old value used", 16'h01F0, 1'b0, 1'b0, 2'd0, 16'h01F0, 1'b1, 8'h7C, 8'hF8);
    do_ack("R9 new value next", 16'h01F0, 1'b0, 1'b1, 2'd0, 16'h01F0);
    do_ack("R2 ch0 field replaced", 16'h00A0, 1'b0, 1'b0, 2'd0, 16'h00A0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_match();
    t_priority();
    t_decode();
    t_race();
    t_same_cycle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule